// File: doc/BRIEF.md
# Interlaced Raster Field Sequencer

This block walks the pixel positions of a video raster and streams them out as coordinate beats under valid/ready flow control. Each beat carries the column of its first pixel, the line number within the current field, a lane mask for the pixels in the beat that fall inside the line, an end-of-line flag, a start-of-field flag and a field identifier. Downstream pattern or colour logic consumes the beats and turns them into pixels. The block itself does no colour generation.

The geometry inputs are width, height, a 4-bit interlace code and a chroma-format code. The block samples them only when a new frame begins. A progressive code makes each frame one field with the full height. An interlaced code splits the frame into two fields of half height each. The fields are sent in the order the code selects. A geometry that breaks a subsampling rule is refused: the block raises an error flag and repeats the last geometry it accepted.

Top module: `raster_field_seq`

## Requirements
- R1: While `rst` is high, `outValid` is 0. On the first beat after reset, `outX`=0, `outY`=0 and `outSof`=1.
- R2: `outX` advances by PIX on each accepted beat. After the beat flagged `outEol`, `outX` returns to 0 and `outY` increments. `outEol` is 1 exactly when `outX`+PIX >= width. Bit i of `outLaneMask` is 1 exactly when `outX`+i < width.
- R3: While `outValid`=1 and `outReady`=0, every output holds its value.
- R4: With interlace codes 0 to 7, each frame is one field with `outField`=0 and a number of lines equal to the height.
- R5: With codes 8 to 11, a frame is two fields: first `outField`=0, then `outField`=1. Each field has floor(height/2) lines.
- R6: With codes 12 to 15, a frame is two fields: first `outField`=1, then `outField`=0. Each field has floor(height/2) lines.
- R7: `outSof` is 1 on the first beat of every field and 0 on every other beat.
- R8: The block loads geometry and interlace code only on the cycle that begins a frame. A change during a frame, including between its two fields, takes effect on the next frame.
- R9: Chroma codes are 0 = 4:4:4, 1 = 4:2:2, 2 = 4:2:0 and 3 = reserved. A configuration is illegal if any of these holds:
  - width or height is 0 or larger than MAX_DIM;
  - the chroma code is 3;
  - the chroma is 4:2:2 or 4:2:0 and the width is odd, or PIX is odd and greater than 1;
  - the chroma is 4:2:0 and the height is odd;
  - the code is interlaced and the height is below 2.

  At a frame start with an illegal configuration, `cfgError` becomes 1 and the previous geometry and interlace mode are reused.
- R10: At a frame start with a legal configuration, `cfgError` returns to 0 and the new geometry is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWidth | input | DW | Requested line width in pixels |
| cfgHeight | input | DW | Requested frame height in lines |
| cfgIlace | input | 4 | Interlace code |
| cfgChroma | input | 2 | Chroma format code |
| outReady | input | 1 | Downstream accepts the beat |
| outValid | output | 1 | Beat present |
| outX | output | DW | Column of the first pixel in the beat |
| outY | output | DW | Line within the current field |
| outLaneMask | output | PIX | Pixels of the beat inside the line |
| outEol | output | 1 | Last beat of the line |
| outSof | output | 1 | First beat of a field |
| outField | output | 1 | Field identifier (0 = F0, 1 = F1) |
| cfgError | output | 1 | The last frame-start configuration was refused |

## Verification
The hardest case to reach is a configuration change that lands between the two fields of an interlaced frame. The second field must keep the first field's line count and the frame's field order, and the new order must then appear on the next frame. The stimulus changes the inputs while the first field is still streaming. It then checks both fields of that frame beat by beat, and after that checks the next frame, which has the opposite field order. Refusal is driven the same way: a series of illegal configurations is applied one frame at a time. Each must leave the previous raster unchanged and keep the error flag set, until a legal 4:2:0 configuration clears it.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  // Chroma format codes seen on cfgChroma.
  typedef enum logic [1:0] {
    CHROMA_444  = 2'd0,
    CHROMA_422  = 2'd1,
    CHROMA_420  = 2'd2,
    CHROMA_RSVD = 2'd3
  } chroma_e;

  // Strobes from control to the coordinate datapath.
  typedef struct packed {
    logic clearPos;   // restart at column 0, line 0
    logic stepBeat;   // move to next beat on the same line
    logic stepLine;   // wrap to column 0 of the next line
  } pos_strobe_t;

endpackage

// File: rtl/rfs_cfg_check.sv
module rfs_cfg_check
  import rfs_pkg::*;
#(
  parameter int MAX_DIM = 16384,
  parameter int PIX     = 4,
  localparam int DW     = $clog2(MAX_DIM + 1)
) (
  input  logic [DW-1:0] width,
  input  logic [DW-1:0] height,
  input  logic [3:0]    ilace,
  input  logic [1:0]    chroma,
  output logic          legal
);

  localparam bit PIX_OK = (PIX == 1) || ((PIX % 2) == 0);

  logic widthOk;
  logic heightOk;
  logic subsampled;
  logic subRuleOk;
  logic vertRuleOk;
  logic fieldRuleOk;

  always_comb begin
    widthOk     = (width != '0) && (width <= DW'(MAX_DIM));
    heightOk    = (height != '0) && (height <= DW'(MAX_DIM));
    subsampled  = (chroma == CHROMA_422) || (chroma == CHROMA_420);
    subRuleOk   = !subsampled || (!width[0] && PIX_OK);
    vertRuleOk  = (chroma != CHROMA_420) || !height[0];
    fieldRuleOk = !ilace[3] || (height >= DW'(2));
    legal       = widthOk && heightOk && (chroma != CHROMA_RSVD) &&
                  subRuleOk && vertRuleOk && fieldRuleOk;
  end

endmodule

// File: rtl/rfs_datapath.sv
module rfs_datapath
  import rfs_pkg::*;
#(
  parameter int MAX_DIM = 16384,
  parameter int PIX     = 4,
  localparam int DW     = $clog2(MAX_DIM + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  pos_strobe_t    strobes,
  input  logic           valid,
  input  logic [DW-1:0]  actWidth,
  input  logic [DW-1:0]  fieldLines,
  output logic [DW-1:0]  posX,
  output logic [DW-1:0]  posY,
  output logic [PIX-1:0] laneMask,
  output logic           lastBeat,
  output logic           lastLine
);

  logic [DW-1:0] xReg;
  logic [DW-1:0] yReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      xReg <= '0;
      yReg <= '0;
    end else if (strobes.clearPos) begin
      xReg <= '0;
      yReg <= '0;
    end else if (strobes.stepLine) begin
      xReg <= '0;
      yReg <= yReg + DW'(1);
    end else if (strobes.stepBeat) begin
      xReg <= xReg + DW'(PIX);
    end
  end

  assign lastBeat = ({1'b0, xReg} + (DW+1)'(PIX)) >= {1'b0, actWidth};
  assign lastLine = ({1'b0, yReg} + (DW+1)'(1)) >= {1'b0, fieldLines};
  assign posX     = xReg;
  assign posY     = yReg;

  for (genvar lane = 0; lane < PIX; lane++) begin : gLane
    assign laneMask[lane] = ({1'b0, xReg} + (DW+1)'(lane)) < {1'b0, actWidth};
  end

  // R2
  x_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (xReg < actWidth));

  // R4
  y_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (yReg < fieldLines));

endmodule

// File: rtl/rfs_control.sv
module rfs_control
  import rfs_pkg::*;
#(
  parameter int MAX_DIM    = 16384,
  parameter int DEF_WIDTH  = 16,
  parameter int DEF_HEIGHT = 8,
  localparam int DW        = $clog2(MAX_DIM + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          outReady,
  input  logic [DW-1:0] cfgWidth,
  input  logic [DW-1:0] cfgHeight,
  input  logic [3:0]    cfgIlace,
  input  logic          cfgLegal,
  input  logic          lastBeat,
  input  logic          lastLine,
  output pos_strobe_t   strobes,
  output logic          valid,
  output logic          sof,
  output logic          field,
  output logic          cfgError,
  output logic [DW-1:0] actWidth,
  output logic [DW-1:0] fieldLines
);

  logic          loadPending;
  logic          secondField;
  logic          atFieldStart;
  logic [DW-1:0] actHeight;
  logic [3:0]    actIlace;

  logic handshake;
  logic fieldEnd;
  logic interlaced;
  logic frameEnd;
  logic startFrame;
  logic nextField;

  always_comb begin
    handshake  = valid && outReady;
    fieldEnd   = handshake && lastBeat && lastLine;
    interlaced = actIlace[3];
    frameEnd   = fieldEnd && (!interlaced || secondField);
    startFrame = loadPending || frameEnd;
    nextField  = fieldEnd && interlaced && !secondField;

    strobes.clearPos = startFrame || nextField;
    strobes.stepBeat = handshake && !lastBeat;
    strobes.stepLine = handshake && lastBeat && !lastLine;

    fieldLines = interlaced ? (actHeight >> 1) : actHeight;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid        <= 1'b0;
      loadPending  <= 1'b1;
      secondField  <= 1'b0;
      atFieldStart <= 1'b0;
      field        <= 1'b0;
      cfgError     <= 1'b0;
      actWidth     <= DW'(DEF_WIDTH);
      actHeight    <= DW'(DEF_HEIGHT);
      actIlace     <= 4'd0;
    end else if (startFrame) begin
      valid        <= 1'b1;
      loadPending  <= 1'b0;
      secondField  <= 1'b0;
      atFieldStart <= 1'b1;
      if (cfgLegal) begin
        actWidth  <= cfgWidth;
        actHeight <= cfgHeight;
        actIlace  <= cfgIlace;
        field     <= (cfgIlace[3:2] == 2'b11);
        cfgError  <= 1'b0;
      end else begin
        field     <= (actIlace[3:2] == 2'b11);
        cfgError  <= 1'b1;
      end
    end else if (nextField) begin
      field        <= ~field;
      secondField  <= 1'b1;
      atFieldStart <= 1'b1;
    end else if (handshake) begin
      atFieldStart <= 1'b0;
    end
  end

  assign sof = valid && atFieldStart;

  // R4
  prog_field_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !actIlace[3]) |-> !field);

  // R5
  field_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    nextField |=> (field != $past(field)));

  // R8
  cfg_frame_only_chk: assert property (@(posedge clk) disable iff (rst)
    !startFrame |=> ($stable(actWidth) && $stable(actHeight) && $stable(actIlace)));

  // R9
  hold_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (startFrame && !cfgLegal) |=> (cfgError && $stable(actWidth) && $stable(actHeight)));

endmodule

// File: rtl/raster_field_seq.sv
module raster_field_seq
  import rfs_pkg::*;
#(
  parameter int MAX_DIM    = 16384,
  parameter int PIX        = 4,
  parameter int DEF_WIDTH  = 16,
  parameter int DEF_HEIGHT = 8,
  localparam int DW        = $clog2(MAX_DIM + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  cfgWidth,
  input  logic [DW-1:0]  cfgHeight,
  input  logic [3:0]     cfgIlace,
  input  logic [1:0]     cfgChroma,
  input  logic           outReady,
  output logic           outValid,
  output logic [DW-1:0]  outX,
  output logic [DW-1:0]  outY,
  output logic [PIX-1:0] outLaneMask,
  output logic           outEol,
  output logic           outSof,
  output logic           outField,
  output logic           cfgError
);

  pos_strobe_t   strobes;
  logic          cfgLegal;
  logic          lastBeat;
  logic          lastLine;
  logic [DW-1:0] actWidth;
  logic [DW-1:0] fieldLines;

  rfs_cfg_check #(.MAX_DIM(MAX_DIM), .PIX(PIX)) uCheck (
    .width  (cfgWidth),
    .height (cfgHeight),
    .ilace  (cfgIlace),
    .chroma (cfgChroma),
    .legal  (cfgLegal)
  );

  rfs_control #(.MAX_DIM(MAX_DIM), .DEF_WIDTH(DEF_WIDTH), .DEF_HEIGHT(DEF_HEIGHT)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .outReady   (outReady),
    .cfgWidth   (cfgWidth),
    .cfgHeight  (cfgHeight),
    .cfgIlace   (cfgIlace),
    .cfgLegal   (cfgLegal),
    .lastBeat   (lastBeat),
    .lastLine   (lastLine),
    .strobes    (strobes),
    .valid      (outValid),
    .sof        (outSof),
    .field      (outField),
    .cfgError   (cfgError),
    .actWidth   (actWidth),
    .fieldLines (fieldLines)
  );

  rfs_datapath #(.MAX_DIM(MAX_DIM), .PIX(PIX)) uPath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .valid      (outValid),
    .actWidth   (actWidth),
    .fieldLines (fieldLines),
    .posX       (outX),
    .posY       (outY),
    .laneMask   (outLaneMask),
    .lastBeat   (lastBeat),
    .lastLine   (lastLine)
  );

  assign outEol = lastBeat;

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outX) && $stable(outY) &&
                                 $stable(outField) && $stable(outSof) && $stable(outEol)));

  // R7
  sof_origin_chk: assert property (@(posedge clk) disable iff (rst)
    outSof |-> (outX == '0 && outY == '0));

endmodule

// File: tb/raster_field_seq_test.sv
module raster_field_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_DIM    = 16384;
  localparam int PIX        = 4;
  localparam int DW         = $clog2(MAX_DIM + 1);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [DW-1:0]  cfgWidth;
  logic [DW-1:0]  cfgHeight;
  logic [3:0]     cfgIlace;
  logic [1:0]     cfgChroma;
  logic           outReady;
  logic           outValid;
  logic [DW-1:0]  outX;
  logic [DW-1:0]  outY;
  logic [PIX-1:0] outLaneMask;
  logic           outEol;
  logic           outSof;
  logic           outField;
  logic           cfgError;

  int totalChecks = 0;
  int failedChecks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_field_seq #(.MAX_DIM(MAX_DIM), .PIX(PIX)) uut (
    .clk(clk), .rst(rst), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .cfgIlace(cfgIlace), .cfgChroma(cfgChroma), .outReady(outReady),
    .outValid(outValid), .outX(outX), .outY(outY), .outLaneMask(outLaneMask),
    .outEol(outEol), .outSof(outSof), .outField(outField), .cfgError(cfgError)
  );

  task automatic report();
    $display("%0d/%0d checks passed", totalChecks - failedChecks, totalChecks);
    $finish;
  endtask

  task automatic check(input bit ok, input string what);
    totalChecks++;
    if (!ok) begin
      failedChecks++;
      $display("FAIL %s", what);
    end
  endtask

  task automatic setCfg(input int w, input int h, input int il, input int ch);
    cfgWidth  = DW'(w);
    cfgHeight = DW'(h);
    cfgIlace  = 4'(il);
    cfgChroma = 2'(ch);
  endtask

  // Walks one whole field with ready held high, starting at its first beat.
  task automatic expectField(input int w, input int lines, input bit fld, input string tag);
    bit bad = 0;
    for (int yy = 0; yy < lines; yy++) begin
      for (int xx = 0; xx < w; xx += PIX) begin
        logic [PIX-1:0] m;
        bit eolE;
        bit sofE;
        for (int i = 0; i < PIX; i++) m[i] = (xx + i < w);
        eolE = (xx + PIX >= w);
        sofE = (xx == 0 && yy == 0);
        if (!bad && (outValid !== 1'b1 || outX !== DW'(xx) || outY !== DW'(yy) ||
                     outLaneMask !== m || outEol !== eolE || outSof !== sofE ||
                     outField !== fld)) begin
          bad = 1;
          $display("FAIL %s: got v=%b x=%0d y=%0d mask=%b eol=%b sof=%b fld=%b, expected v=1 x=%0d y=%0d mask=%b eol=%b sof=%b fld=%b",
                   tag, outValid, outX, outY, outLaneMask, outEol, outSof, outField,
                   xx, yy, m, eolE, sofE, fld);
        end
        @(negedge clk);
      end
    end
    totalChecks++;
    if (bad) failedChecks++;
  endtask

  task automatic testReset();
    setCfg(6, 3, 0, 0);
    outReady = 1'b1;
    rst = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(outValid === 1'b0, $sformatf("R1 valid in reset: got %b expected 0", outValid));
    end
    rst = 1'b0;
    @(negedge clk);
    check(outValid === 1'b1 && outX === '0 && outY === '0 && outSof === 1'b1,
          $sformatf("R1 first beat: got v=%b x=%0d y=%0d sof=%b expected 1 0 0 1",
                    outValid, outX, outY, outSof));
    expectField(6, 3, 0, "R2 width 6 partial last beat");
  endtask

  task automatic testMidFrameCfg();
    setCfg(8, 2, 5, 0);
    expectField(6, 3, 0, "R8 running frame keeps old geometry");
    expectField(8, 2, 0, "R4 code 5 progressive");
  endtask

  task automatic testF0First();
    setCfg(5, 5, 9, 0);
    expectField(8, 2, 0, "R4 repeat frame");
    setCfg(3, 4, 13, 0);
    expectField(5, 2, 0, "R5 first field F0 floor(5/2) lines");
    expectField(5, 2, 1, "R5 R8 second field keeps frame cfg");
  endtask

  task automatic testF1First();
    setCfg(12, 1, 0, 1);
    expectField(3, 2, 1, "R6 first field F1");
    expectField(3, 2, 0, "R6 second field F0");
  endtask

  task automatic testStall();
    outReady = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(outValid === 1'b1 && outX === '0 && outY === '0 && outSof === 1'b1 && outEol === 1'b0,
            $sformatf("R3 stalled beat: got v=%b x=%0d y=%0d sof=%b eol=%b expected 1 0 0 1 0",
                      outValid, outX, outY, outSof, outEol));
    end
    outReady = 1'b1;
    @(negedge clk);
    check(outX === DW'(4) && outSof === 1'b0 && outEol === 1'b0,
          $sformatf("R7 after stall: got x=%0d sof=%b eol=%b expected 4 0 0", outX, outSof, outEol));
    @(negedge clk);
    check(outX === DW'(8) && outEol === 1'b1 && outLaneMask === 4'b1111,
          $sformatf("R2 last beat width 12: got x=%0d eol=%b mask=%b expected 8 1 1111",
                    outX, outEol, outLaneMask));
    @(negedge clk);
    check(outX === '0 && outY === '0 && outSof === 1'b1,
          $sformatf("R7 next frame start: got x=%0d y=%0d sof=%b expected 0 0 1", outX, outY, outSof));
  endtask

  task automatic testIllegal();
    int wl[6] = '{7, 4, 4, 4, 0, 16385};
    int hl[6] = '{2, 3, 2, 1, 2, 2};
    int il[6] = '{0, 0, 0, 8, 0, 0};
    int cl[6] = '{1, 2, 3, 0, 0, 0};
    for (int k = 0; k < 6; k++) begin
      setCfg(wl[k], hl[k], il[k], cl[k]);
      expectField(12, 1, 0, $sformatf("R9 illegal case %0d keeps 12x1", k));
      check(cfgError === 1'b1, $sformatf("R9 error for case %0d: got %b expected 1", k, cfgError));
    end
  endtask

  task automatic testRecover();
    setCfg(4, 2, 0, 2);
    expectField(12, 1, 0, "R9 last refused frame");
    check(cfgError === 1'b0, $sformatf("R10 error cleared: got %b expected 0", cfgError));
    setCfg(1, 2, 0, 0);
    expectField(4, 2, 0, "R10 legal 4:2:0 geometry");
    expectField(1, 2, 0, "R2 width 1");
  endtask

  initial begin
    testReset();
    testMidFrameCfg();
    testF0First();
    testF1First();
    testStall();
    testIllegal();
    testRecover();
    finished = 1;
    report();
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      totalChecks++;
      failedChecks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      report();
    end
  end

endmodule